// File: doc/BRIEF.md
# IP Upper-Protocol Extractor

This block follows a layer-2 header parser in a receive path. The L2 stage pulses a start strobe with the first byte of the layer-3 header and presents the final ethertype at the same time. The extractor watches the byte stream from that point. It reads the IPv4 header, or the IPv6 fixed header followed by its chain of extension headers, and reports the layer-4 protocol number.

The extractor stops as soon as the datagram shows it is fragmented. It also stops on a fragment header and on two routing headers in a row. In those cases it reports the reserved value 0xFF but keeps the IP flags set. One done pulse per frame marks the point where the flags and the protocol byte are final. Those outputs then hold until the next start strobe.

Top module: `ip_l4_proto_extract`

## Requirements
- R1: On `l3_start`, an ethertype of 0x0800 sets `ip_seen`=1 and `ip6`=0, and 0x86DD sets both to 1. Any other ethertype gives `ip_seen`=0, `ip6`=0 and `proto`=0xFF, with `done` in the cycle after the start strobe.
- R2: For an IPv4 frame that is not fragmented, `proto` equals L3 byte 9 (byte 0 is the byte presented with `l3_start`). `done` pulses in the cycle after byte 9 is accepted.
- R3: An IPv4 frame is fragmented when byte 6 bit 5 (more-fragments) is 1, or when the 13-bit offset made of byte 6 bits 4:0 and byte 7 is nonzero. Parsing then stops after byte 7 with `proto`=0xFF, `ip_seen`=1 and `done` in the next cycle.
- R4: For IPv6, the next-header value sits in byte 6 and the fixed header is 40 bytes long. When the value that follows the fixed header or an extension header is not 0, 43, 44 or 60, `proto` takes that value (6 for TCP, 17 for UDP, otherwise the raw value). `done` pulses in the cycle after the last byte of the header that carries it.
- R5: Next-header values 0, 43 and 60 are walked as extension headers. Each one carries its own next-header value in byte 0 and a length L in byte 1, and is (L+1)*8 bytes long.
- R6: Next-header value 44 (fragment) ends parsing with `proto`=0xFF, `ip_seen`=1 and `ip6`=1.
- R7: A routing header (43) whose next-header value is again 43 ends parsing with `proto`=0xFF.
- R8: If `frame_end` arrives before a result, `done` pulses in the next cycle with `proto`=0xFF. If the concluding byte carries `frame_end`, only one `done` pulses and it reports the concluded value.
- R9: `done` pulses exactly once per frame. After it, the outputs hold and later bytes and `frame_end` are ignored until the next `l3_start`.
- R10: After reset, `done`=0, `ip_seen`=0, `ip6`=0 and `proto`=0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l3_start | input | 1 | Start of layer 3; given with byte 0 |
| ethertype | input | 16 | Final ethertype from the L2 stage, valid with `l3_start` |
| byte_valid | input | 1 | `byte_data` holds a stream byte |
| byte_data | input | 8 | Stream byte |
| frame_end | input | 1 | Last cycle of the frame |
| ip_seen | output | 1 | Frame carries IPv4 or IPv6 |
| ip6 | output | 1 | Frame carries IPv6 |
| proto | output | 8 | Layer-4 protocol number, or 0xFF |
| done | output | 1 | One-cycle pulse: results are final |

## Verification
A header can conclude on the same byte that carries `frame_end`, so the normal result and the early-end path can both request a done pulse in one cycle. The bench provokes this in two ways:
- It truncates an IPv6 extension chain and an IPv4 header at every possible length, which places the frame end before, on and after the concluding byte.
- It sends one-byte frames whose start strobe and frame end coincide.

A reference walk in the bench predicts the concluding byte for each frame. The bench then checks that exactly one pulse arrives after the predicted byte and that the reported value matches the prediction.

// File: rtl/ipx_pkg.sv
package ipx_pkg;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_V4,
        PS_V6,
        PS_EXT
    } pstate_e;

    typedef enum logic [1:0] {
        NA_EXT,
        NA_ROUTE,
        NA_STOP,
        NA_FINAL
    } nh_act_e;

    localparam logic [7:0]  PROTO_NONE = 8'hFF;
    localparam logic [7:0]  NH_HOP     = 8'd0;
    localparam logic [7:0]  NH_ROUTE   = 8'd43;
    localparam logic [7:0]  NH_FRAG    = 8'd44;
    localparam logic [7:0]  NH_DEST    = 8'd60;
    localparam logic [15:0] ET_IPV4    = 16'h0800;
    localparam logic [15:0] ET_IPV6    = 16'h86DD;

    localparam int V4_FRAG_HI_IDX = 6;
    localparam int V4_FRAG_LO_IDX = 7;
    localparam int V4_PROTO_IDX   = 9;
    localparam int V6_NH_IDX      = 6;
    localparam int V6_LAST_IDX    = 39;

endpackage

// File: rtl/ipx_nh_classify.sv
module ipx_nh_classify
    import ipx_pkg::*;
(
    input  logic [7:0] nh_i,
    input  logic       prev_route_i,
    output nh_act_e    act_o
);

    always_comb begin
        unique case (nh_i)
            NH_HOP, NH_DEST: act_o = NA_EXT;
            NH_ROUTE:        act_o = prev_route_i ? NA_STOP : NA_ROUTE;
            NH_FRAG:         act_o = NA_STOP;
            default:         act_o = NA_FINAL;
        endcase
    end

endmodule

// File: rtl/ipx_byte_idx.sv
module ipx_byte_idx #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_i,
    input  logic             adv_i,
    input  logic             wrap_i,
    output logic [CNT_W-1:0] idx_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (wrap_i) begin
            cnt_d = '0;
        end else if (first_i) begin
            cnt_d = adv_i ? CNT_W'(1) : '0;
        end else if (adv_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign idx_o = first_i ? '0 : cnt_q;

    // R5: an extension header never runs the index past its range
    a_r5_idx_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !wrap_i && !first_i) |-> (cnt_q != '1));

endmodule

// File: rtl/ip_l4_proto_extract.sv
module ip_l4_proto_extract
    import ipx_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        l3_start,
    input  logic [15:0] ethertype,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    input  logic        frame_end,
    output logic        ip_seen,
    output logic        ip6,
    output logic [7:0]  proto,
    output logic        done
);

    localparam logic [CNT_W-1:0] LIM_IDLE = '1;

    typedef struct packed {
        pstate_e          st;
        logic [CNT_W-1:0] lim;
        logic [7:0]       nh;
        logic             route;
        logic             ipseen;
        logic             v6;
        logic [7:0]       proto;
        logic             done;
    } walk_t;

    walk_t   w_d, w_q;
    pstate_e start_st, cur_st;
    nh_act_e act;
    logic [CNT_W-1:0] idx;
    logic    is4, is6, take, at_end, wrap, conclude;
    logic [7:0] c_proto;

    assign is4      = (ethertype == ET_IPV4);
    assign is6      = (ethertype == ET_IPV6);
    assign start_st = is4 ? PS_V4 : (is6 ? PS_V6 : PS_IDLE);
    assign cur_st   = l3_start ? start_st : w_q.st;
    assign take     = byte_valid && (cur_st != PS_IDLE);
    assign at_end   = take && (((cur_st == PS_V6) && (idx == CNT_W'(V6_LAST_IDX))) ||
                               ((cur_st == PS_EXT) && (idx == w_q.lim)));
    assign wrap     = at_end && ((act == NA_EXT) || (act == NA_ROUTE));

    ipx_nh_classify u_cls (
        .nh_i         (w_q.nh),
        .prev_route_i ((cur_st == PS_EXT) && w_q.route),
        .act_o        (act)
    );

    ipx_byte_idx #(.CNT_W(CNT_W)) u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .first_i (l3_start),
        .adv_i   (take),
        .wrap_i  (wrap),
        .idx_o   (idx)
    );

    always_comb begin
        w_d      = w_q;
        w_d.done = 1'b0;
        conclude = 1'b0;
        c_proto  = PROTO_NONE;

        if (l3_start) begin
            w_d.ipseen = is4 || is6;
            w_d.v6     = is6;
            w_d.proto  = PROTO_NONE;
            w_d.st     = start_st;
            w_d.lim    = LIM_IDLE;
            w_d.route  = 1'b0;
            if (!(is4 || is6)) conclude = 1'b1;
        end

        if (take) begin
            unique case (cur_st)
                PS_V4: begin
                    if (idx == CNT_W'(V4_FRAG_HI_IDX))
                        w_d.nh = {7'd0, byte_data[5] | (|byte_data[4:0])};
                    if ((idx == CNT_W'(V4_FRAG_LO_IDX)) && (w_q.nh[0] || (|byte_data)))
                        conclude = 1'b1;
                    if (idx == CNT_W'(V4_PROTO_IDX)) begin
                        conclude = 1'b1;
                        c_proto  = byte_data;
                    end
                end
                PS_V6: begin
                    if (idx == CNT_W'(V6_NH_IDX)) w_d.nh = byte_data;
                end
                PS_EXT: begin
                    if (idx == '0)          w_d.nh  = byte_data;
                    if (idx == CNT_W'(1))   w_d.lim = CNT_W'({byte_data, 3'b111});
                end
                default: ;
            endcase

            if (at_end) begin
                unique case (act)
                    NA_EXT, NA_ROUTE: begin
                        w_d.st    = PS_EXT;
                        w_d.route = (act == NA_ROUTE);
                        w_d.lim   = LIM_IDLE;
                    end
                    NA_STOP:  conclude = 1'b1;
                    NA_FINAL: begin
                        conclude = 1'b1;
                        c_proto  = w_q.nh;
                    end
                    default: ;
                endcase
            end
        end

        if (conclude) begin
            w_d.st    = PS_IDLE;
            w_d.done  = 1'b1;
            w_d.proto = c_proto;
        end else if (frame_end && (cur_st != PS_IDLE)) begin
            w_d.st   = PS_IDLE;
            w_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{st: PS_IDLE, lim: LIM_IDLE, nh: 8'd0, route: 1'b0,
                     ipseen: 1'b0, v6: 1'b0, proto: PROTO_NONE, done: 1'b0};
        end else begin
            w_q <= w_d;
        end
    end

    assign ip_seen = w_q.ipseen;
    assign ip6     = w_q.v6;
    assign proto   = w_q.proto;
    assign done    = w_q.done;

    // R1: a non-IP frame never reports a protocol
    a_r1_nonip_none: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ip_seen) |-> (proto == PROTO_NONE));

    // R1: the IPv6 flag implies the IP flag
    a_r1_v6_is_ip: assert property (@(posedge clk) disable iff (!rst_n)
        ip6 |-> ip_seen);

    // R9: once idle, stream activity yields no pulse and no change
    a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((w_q.st == PS_IDLE) && !l3_start) |=> (!done && $stable(proto)));

    // R9: a pulse only follows an active walk or a start strobe
    a_r9_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(l3_start || (w_q.st != PS_IDLE)));

endmodule

// File: tb/sim_ip_l4_proto_extract.sv
module sim_ip_l4_proto_extract;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l3_start = 1'b0;
    logic [15:0] ethertype = 16'h0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h0;
    logic        frame_end = 1'b0;
    logic        ip_seen, ip6, done;
    logic [7:0]  proto;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] fb [0:1023];

    int         n_done, sent, at_done;
    logic [7:0] g_proto;
    logic       g_ip, g_v6;

    always #10 clk = ~clk;

    ip_l4_proto_extract u0 (
        .clk(clk), .rst_n(rst_n), .l3_start(l3_start), .ethertype(ethertype),
        .byte_valid(byte_valid), .byte_data(byte_data), .frame_end(frame_end),
        .ip_seen(ip_seen), .ip6(ip6), .proto(proto), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 195000) begin
                errors++;
                $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 195000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    task automatic fill_pattern(input int seed);
        for (int i = 0; i < 1024; i++) fb[i] = 8'((i * 7 + seed * 13 + 3) & 8'hFF);
    endtask

    task automatic put_ext(input int pos, input int nh, input int len);
        fb[pos]     = 8'(nh);
        fb[pos + 1] = 8'(len);
    endtask

    function automatic int ext_size(input int l);
        return (l + 1) * 8;
    endfunction

    // reference walk derived from the requirements
    task automatic model(input logic [15:0] et, input int len,
                         output bit e_ip, output bit e_v6, output int e_p, output int e_k);
        int nh, pos, hl;
        bit route;
        e_ip = (et == 16'h0800) || (et == 16'h86DD);
        e_v6 = (et == 16'h86DD);
        e_p  = 255;
        e_k  = len - 1;
        if (!e_ip) begin
            e_k = 0;
            return;
        end
        if (!e_v6) begin
            if (len < 8) return;
            if (fb[6][5] || (fb[6][4:0] != 0) || (fb[7] != 0)) begin
                e_k = 7;
                return;
            end
            if (len < 10) return;
            e_k = 9;
            e_p = fb[9];
            return;
        end
        if (len < 40) return;
        nh = fb[6];
        pos = 40;
        route = 0;
        forever begin
            if (nh == 43 && route) begin e_k = pos - 1; return; end
            if (nh == 44)          begin e_k = pos - 1; return; end
            if (!(nh == 0 || nh == 43 || nh == 60)) begin
                e_k = pos - 1;
                e_p = nh;
                return;
            end
            if (len < pos + 2) return;
            hl = ext_size(fb[pos + 1]);
            if (len < pos + hl) return;
            route = (nh == 43);
            nh = fb[pos];
            pos = pos + hl;
        end
    endtask

    task automatic observe();
        if (done) begin
            n_done++;
            at_done = sent;
            g_proto = proto;
            g_ip = ip_seen;
            g_v6 = ip6;
        end
    endtask

    task automatic drive_idle();
        l3_start = 1'b0;
        byte_valid = 1'b0;
        frame_end = 1'b0;
    endtask

    task automatic run_frame(input logic [15:0] et, input int len, input bit gap,
                             input string tag);
        bit e_ip, e_v6;
        int e_p, e_k;
        model(et, len, e_ip, e_v6, e_p, e_k);
        n_done = 0;
        sent = 0;
        at_done = -1;
        for (int i = 0; i < len; i++) begin
            if (gap && (i % 3 == 2)) begin
                @(negedge clk);
                observe();
                drive_idle();
            end
            @(negedge clk);
            observe();
            l3_start = (i == 0);
            ethertype = et;
            byte_valid = 1'b1;
            byte_data = fb[i];
            frame_end = (i == len - 1);
            sent++;
        end
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            observe();
            drive_idle();
        end
        chk(n_done == 1, tag, "done count (R9)", n_done, 1);
        chk(at_done == e_k + 1, tag, "bytes before done", at_done, e_k + 1);
        chk(g_ip == e_ip, tag, "ip_seen", g_ip, e_ip);
        chk(g_v6 == e_v6, tag, "ip6", g_v6, e_v6);
        chk(g_proto == 8'(e_p), tag, "proto", g_proto, e_p);
        chk(proto == g_proto, tag, "proto held after done (R9)", proto, g_proto);
    endtask

    task automatic build_chain(input int a, input int b, input int c, input int l,
                               output int flen);
        int p2, p3;
        fb[0] = 8'h60;
        fb[6] = 8'(a);
        put_ext(40, b, l);
        p2 = 40 + ext_size(l);
        put_ext(p2, c, l);
        p3 = p2 + ext_size(l);
        put_ext(p3, 6, 0);
        flen = p3 + 18;
    endtask

    initial begin
        int ets[5] = '{32'h0806, 32'h8100, 32'h86DC, 32'h0801, 32'h0000};
        int kinds[5] = '{0, 43, 60, 44, 17};
        int flen;

        drive_idle();
        repeat (3) @(negedge clk);
        // R10: reset values
        chk(done == 1'b0, "R10", "done", done, 0);
        chk(ip_seen == 1'b0, "R10", "ip_seen", ip_seen, 0);
        chk(ip6 == 1'b0, "R10", "ip6", ip6, 0);
        chk(proto == 8'hFF, "R10", "proto", proto, 255);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: non-IP ethertypes
        foreach (ets[k]) begin
            fill_pattern(k);
            run_frame(16'(ets[k]), 20, 1'b0, "R1 non-IP");
        end
        fill_pattern(9);
        run_frame(16'h0806, 1, 1'b0, "R1 R8 single byte non-IP");

        // R2: IPv4 protocol sweep, with and without gaps
        for (int p = 0; p < 256; p++) begin
            fill_pattern(p);
            fb[0] = 8'h45; fb[6] = 8'h40; fb[7] = 8'h00; fb[9] = 8'(p);
            run_frame(16'h0800, 30, p[0], "R2 IPv4 proto");
        end

        // R3: fragment field sweep
        for (int b6 = 0; b6 < 256; b6++) begin
            fill_pattern(b6);
            fb[0] = 8'h45; fb[6] = 8'(b6); fb[7] = 8'h00; fb[9] = 8'd6;
            run_frame(16'h0800, 30, 1'b0, "R3 IPv4 frag byte6");
        end
        for (int b7 = 1; b7 < 256; b7 = b7 * 2 + 1) begin
            fill_pattern(b7);
            fb[0] = 8'h45; fb[6] = 8'h00; fb[7] = 8'(b7); fb[9] = 8'd17;
            run_frame(16'h0800, 30, 1'b0, "R3 IPv4 frag offset low");
        end

        // R4 R6: IPv6 next-header sweep over the fixed header
        for (int nh = 0; nh < 256; nh++) begin
            fill_pattern(nh);
            fb[0] = 8'h60; fb[6] = 8'(nh);
            put_ext(40, 17, 0);
            put_ext(48, 6, 0);
            run_frame(16'h86DD, 70, 1'b0, "R4 R6 IPv6 next header");
        end

        // R5 R6 R7: extension chains
        foreach (kinds[a]) foreach (kinds[b]) foreach (kinds[c])
            for (int l = 0; l < 2; l++) begin
                fill_pattern(a * 25 + b * 5 + c);
                build_chain(kinds[a], kinds[b], kinds[c], l, flen);
                run_frame(16'h86DD, flen, l[0], "R5 R6 R7 chain");
            end

        // R8: truncation at every length, IPv6 chain and IPv4
        for (int len = 1; len <= 76; len++) begin
            fill_pattern(3);
            fb[0] = 8'h60; fb[6] = 8'd0;
            put_ext(40, 43, 1);
            put_ext(56, 60, 0);
            put_ext(64, 17, 0);
            run_frame(16'h86DD, len, 1'b0, "R8 IPv6 truncation");
        end
        for (int len = 1; len <= 12; len++) begin
            fill_pattern(4);
            fb[0] = 8'h45; fb[6] = 8'h00; fb[7] = 8'h00; fb[9] = 8'd17;
            run_frame(16'h0800, len, 1'b0, "R8 IPv4 truncation");
            fb[6] = 8'h20;
            run_frame(16'h0800, len, 1'b0, "R8 R3 IPv4 frag truncation");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule